// File: doc/BRIEF.md
# Event Timer with One Comparator Channel

This block is a register-mapped event timer. A free-running 64-bit up-counter advances by one on every clock while a global run bit is set. A single comparator channel watches it. When the counter reaches the comparator value, the channel sets a sticky status bit and, if its interrupt enable is on, drives the interrupt output. Software reaches every register through a simple 32-bit register bus with byte addresses. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge.

The channel has two modes. In one-shot mode the comparator keeps its value after a match. In periodic mode the comparator is advanced by the most recently written period on every match. A self-clearing preset bit lets software load the comparator itself while periodic mode is on. A narrow mode confines the comparison, the periodic reload and the counter to 32 bits. In that mode the upper counter word is held at zero and reads as zero. Software reads the counter one word at a time, so a high/low/high sequence shows a carry that happened between the reads.

Top module: `evtimer_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The register map is: 0x00 run control (bit0 = run), 0x04 status, 0x08 counter low, 0x0C counter high, 0x10 channel config, 0x14 comparator low, 0x18 comparator high.
- R2: Writes to 0x08 or 0x0C load the counter only while the run bit is 0. Such a write made while the counter runs leaves the counter unchanged.
- R3: The low counter word (0x08) and the high counter word (0x0C) can each be read on its own. A high, low, high read sequence across a low-word wrap returns two different high values.
- R4: While run is 1 and narrow mode is off, the 64-bit counter rises by exactly one per clock.
- R5: A match occurs when run is 1 and the counter equals the comparator. A match sets status bit0 (0x04). In one-shot mode (config bit1 = 0) the comparator keeps its value.
- R6: Writing 1 to status bit0 clears it. `irq` is high exactly when status bit0 and the config interrupt enable (bit0) are both 1.
- R7: A write to either comparator word always loads the matching half of the period. The comparator half itself is loaded only when periodic mode is off or the preset bit (config bit2) is 1. Any comparator write clears config bit2.
- R8: In periodic mode (config bit1 = 1) a match adds the period to the comparator. In narrow mode the addition covers the low 32 bits only, wraps modulo 2^32, and leaves the upper comparator word unchanged.
- R9: In narrow mode (config bit3 = 1) a match compares the low 32 bits only. The upper comparator word has no effect on matching.
- R10: In narrow mode the low counter word wraps to zero with no carry upward. The high counter word reads zero, and writes to it have no effect.
- R11: If a match and a status clear fall in the same cycle, the status bit ends set.
- R12: If a match in periodic mode and a direct comparator load fall in the same cycle, the written value is kept and no reload takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational from the address |
| irq | output | 1 | Interrupt: status bit gated by interrupt enable |

## Verification
Two pairs of events can land in the same clock edge. The first pair is a match and a software write-1-to-clear of the status bit. The second pair is a periodic reload and a direct comparator load.

Each collision is set up the same way. The counter is halted at exactly the comparator value, and the run-bit write is placed directly in front of the competing bus write. The match then lands on the very edge where that write commits. The outcome is read back through the status register or the comparator register and compared with the stated priority (R11, R12). A cycle-accurate behavioural model also checks `irq` on every cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // Byte offsets of the registers
    localparam int OFF_RUN  = 0;
    localparam int OFF_STAT = 4;
    localparam int OFF_CNTL = 8;
    localparam int OFF_CNTH = 12;
    localparam int OFF_CFG  = 16;
    localparam int OFF_CMPL = 20;
    localparam int OFF_CMPH = 24;

    // Channel configuration, bit3..bit0
    typedef struct packed {
        logic narrow;    // bit3: 32-bit operation
        logic preset;    // bit2: direct comparator load in periodic mode
        logic periodic;  // bit1
        logic inten;     // bit0
    } chcfg_t;

    // One write strobe per register
    typedef struct packed {
        logic run;
        logic stat;
        logic cntl;
        logic cnth;
        logic cfg;
        logic cmpl;
        logic cmph;
    } wstb_t;

    function automatic chcfg_t cfg_unpack(input logic [3:0] w);
        chcfg_t c;
        c.narrow   = w[3];
        c.preset   = w[2];
        c.periodic = w[1];
        c.inten    = w[0];
        return c;
    endfunction

endpackage

// File: rtl/evt_regbus.sv
module evt_regbus
    import evt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 32
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              run,
    input  logic              stat,
    input  chcfg_t            cfg,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    input  logic [WORD_W-1:0] cmp_lo,
    input  logic [WORD_W-1:0] cmp_hi,
    output wstb_t             wstb,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        wstb = '0;
        if (bus_sel && bus_we) begin
            case (bus_addr)
                ADDR_W'(OFF_RUN):  wstb.run  = 1'b1;
                ADDR_W'(OFF_STAT): wstb.stat = 1'b1;
                ADDR_W'(OFF_CNTL): wstb.cntl = 1'b1;
                ADDR_W'(OFF_CNTH): wstb.cnth = 1'b1;
                ADDR_W'(OFF_CFG):  wstb.cfg  = 1'b1;
                ADDR_W'(OFF_CMPL): wstb.cmpl = 1'b1;
                ADDR_W'(OFF_CMPH): wstb.cmph = 1'b1;
                default:           wstb      = '0;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_RUN):  rdata = WORD_W'(run);
            ADDR_W'(OFF_STAT): rdata = WORD_W'(stat);
            ADDR_W'(OFF_CNTL): rdata = cnt_lo;
            ADDR_W'(OFF_CNTH): rdata = cfg.narrow ? '0 : cnt_hi;
            ADDR_W'(OFF_CFG):  rdata = WORD_W'(cfg);
            ADDR_W'(OFF_CMPL): rdata = cmp_lo;
            ADDR_W'(OFF_CMPH): rdata = cmp_hi;
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              narrow,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cnt_lo,
    output logic [WORD_W-1:0] cnt_hi
);

    localparam int CNT_W = 2 * WORD_W;
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [WORD_W-1:0] WORD_ONE = WORD_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            if (!run) begin
                if (wr_lo) cnt_q[WORD_W-1:0]     <= wdata;
                if (wr_hi) cnt_q[CNT_W-1:WORD_W] <= wdata;
            end else if (narrow) begin
                cnt_q[WORD_W-1:0] <= cnt_q[WORD_W-1:0] + WORD_ONE;
            end else begin
                cnt_q <= cnt_q + CNT_ONE;
            end
            if (narrow) cnt_q[CNT_W-1:WORD_W] <= '0;
        end
    end

    assign cnt_lo = cnt_q[WORD_W-1:0];
    assign cnt_hi = cnt_q[CNT_W-1:WORD_W];

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    input  logic              cfg_we,
    input  logic              stat_we,
    input  logic              cmpl_we,
    input  logic              cmph_we,
    input  logic [WORD_W-1:0] wdata,
    output chcfg_t            cfg,
    output logic              stat,
    output logic [WORD_W-1:0] cmp_lo,
    output logic [WORD_W-1:0] cmp_hi,
    output logic              irq
);

    localparam int CNT_W = 2 * WORD_W;

    chcfg_t           cfg_q;
    logic             stat_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per;
    logic [1:0]       half_we;
    logic             match;
    logic             load_lo;
    logic             load_hi;
    logic [CNT_W-1:0] cmp_next;

    assign half_we = {cmph_we, cmpl_we};

    // Period halves: each written by any write to its comparator word
    for (genvar h = 0; h < 2; h++) begin : g_per
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)             q <= '0;
            else if (half_we[h]) q <= wdata;
        end
        assign per[h*WORD_W +: WORD_W] = q;
    end

    assign match = run && (cfg_q.narrow ? (cnt_lo == cmp_q[WORD_W-1:0])
                                        : ({cnt_hi, cnt_lo} == cmp_q));

    assign load_lo = cmpl_we && (!cfg_q.periodic || cfg_q.preset);
    assign load_hi = cmph_we && (!cfg_q.periodic || cfg_q.preset);

    always_comb begin
        if (cfg_q.narrow)
            cmp_next = {cmp_q[CNT_W-1:WORD_W], cmp_q[WORD_W-1:0] + per[WORD_W-1:0]};
        else
            cmp_next = cmp_q + per;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (load_lo || load_hi) begin
            if (load_lo) cmp_q[WORD_W-1:0]     <= wdata;
            if (load_hi) cmp_q[CNT_W-1:WORD_W] <= wdata;
        end else if (match && cfg_q.periodic) begin
            cmp_q <= cmp_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        cfg_q <= '0;
        else if (cfg_we)                cfg_q <= cfg_unpack(wdata[3:0]);
        else if (cmpl_we || cmph_we)    cfg_q.preset <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                        stat_q <= 1'b0;
        else if (match)                 stat_q <= 1'b1;
        else if (stat_we && wdata[0])   stat_q <= 1'b0;
    end

    assign cfg    = cfg_q;
    assign stat   = stat_q;
    assign cmp_lo = cmp_q[WORD_W-1:0];
    assign cmp_hi = cmp_q[CNT_W-1:WORD_W];
    assign irq    = stat_q && cfg_q.inten;

endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    wstb_t             wstb;
    logic              run_q;
    chcfg_t            cfg_w;
    logic              stat_w;
    logic [WORD_W-1:0] cnt_lo_w;
    logic [WORD_W-1:0] cnt_hi_w;
    logic [WORD_W-1:0] cmp_lo_w;
    logic [WORD_W-1:0] cmp_hi_w;

    evt_regbus #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bus (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .run     (run_q),
        .stat    (stat_w),
        .cfg     (cfg_w),
        .cnt_lo  (cnt_lo_w),
        .cnt_hi  (cnt_hi_w),
        .cmp_lo  (cmp_lo_w),
        .cmp_hi  (cmp_hi_w),
        .wstb    (wstb),
        .rdata   (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)           run_q <= 1'b0;
        else if (wstb.run) run_q <= bus_wdata[0];
    end

    evt_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q),
        .narrow(cfg_w.narrow),
        .wr_lo (wstb.cntl),
        .wr_hi (wstb.cnth),
        .wdata (bus_wdata),
        .cnt_lo(cnt_lo_w),
        .cnt_hi(cnt_hi_w)
    );

    evt_channel #(.WORD_W(WORD_W)) u_ch (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .cnt_lo (cnt_lo_w),
        .cnt_hi (cnt_hi_w),
        .cfg_we (wstb.cfg),
        .stat_we(wstb.stat),
        .cmpl_we(wstb.cmpl),
        .cmph_we(wstb.cmph),
        .wdata  (bus_wdata),
        .cfg    (cfg_w),
        .stat   (stat_w),
        .cmp_lo (cmp_lo_w),
        .cmp_hi (cmp_hi_w),
        .irq    (irq)
    );

endmodule

// File: rtl/evt_checker.sv
module evt_checker
    import evt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              run,
    input chcfg_t            cfg,
    input logic              stat,
    input logic [WORD_W-1:0] cnt_lo,
    input logic [WORD_W-1:0] cnt_hi,
    input logic [WORD_W-1:0] cmp_lo,
    input logic [WORD_W-1:0] cmp_hi,
    input logic              irq
);

    logic wr_cnt, wr_cmp, wr_clr, hit;

    assign wr_cnt = bus_sel && bus_we &&
                    (bus_addr == ADDR_W'(OFF_CNTL) || bus_addr == ADDR_W'(OFF_CNTH));
    assign wr_cmp = bus_sel && bus_we &&
                    (bus_addr == ADDR_W'(OFF_CMPL) || bus_addr == ADDR_W'(OFF_CMPH));
    assign wr_clr = bus_sel && bus_we && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0];
    assign hit    = run && (cfg.narrow ? (cnt_lo == cmp_lo) : ({cnt_hi, cnt_lo} == {cmp_hi, cmp_lo}));

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt_lo));                                 // R2

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !cfg.narrow) |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1)); // R4

    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg.narrow |=> (cnt_hi == '0));                                         // R10

    AST_ONESHOT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!cfg.periodic && !wr_cmp) |=> $stable({cmp_hi, cmp_lo}));              // R5

    AST_PRESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_cmp |=> !cfg.preset);                                                // R7

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        hit |=> stat);                                                          // R11

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat && !wr_clr) |=> stat);                                            // R6

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat && cfg.inten));                                           // R6

endmodule

bind evtimer_top evt_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .run      (run_q),
    .cfg      (cfg_w),
    .stat     (stat_w),
    .cnt_lo   (cnt_lo_w),
    .cnt_hi   (cnt_hi_w),
    .cmp_lo   (cmp_lo_w),
    .cmp_hi   (cmp_hi_w),
    .irq      (irq)
);

// File: tb/sim_evtimer_top.sv
module sim_evtimer_top;
    import evt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evtimer_top u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference model
    logic        m_run, m_stat, m_ie, m_pm, m_ps, m_nw;
    logic [63:0] m_cnt, m_cmp, m_per;
    logic        n_hit, n_wr, n_ll, n_lh;
    logic [63:0] n_cnt, n_cmp;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_stat = 0; m_ie = 0; m_pm = 0; m_ps = 0; m_nw = 0;
            m_cnt = 0; m_cmp = 0; m_per = 0;
        end else begin
            n_wr  = bus_sel && bus_we;
            n_hit = m_run && (m_nw ? (m_cnt[31:0] == m_cmp[31:0]) : (m_cnt == m_cmp));
            n_cnt = m_cnt;
            if (!m_run) begin
                if (n_wr && bus_addr == 5'(OFF_CNTL)) n_cnt[31:0]  = bus_wdata;
                if (n_wr && bus_addr == 5'(OFF_CNTH)) n_cnt[63:32] = bus_wdata;
            end else if (m_nw) n_cnt[31:0] = m_cnt[31:0] + 32'd1;
            else n_cnt = m_cnt + 64'd1;
            if (m_nw) n_cnt[63:32] = 0;
            n_ll = n_wr && bus_addr == 5'(OFF_CMPL) && (!m_pm || m_ps);
            n_lh = n_wr && bus_addr == 5'(OFF_CMPH) && (!m_pm || m_ps);
            n_cmp = m_cmp;
            if (n_ll || n_lh) begin
                if (n_ll) n_cmp[31:0]  = bus_wdata;
                if (n_lh) n_cmp[63:32] = bus_wdata;
            end else if (n_hit && m_pm) begin
                if (m_nw) n_cmp[31:0] = m_cmp[31:0] + m_per[31:0];
                else n_cmp = m_cmp + m_per;
            end
            if (n_wr && bus_addr == 5'(OFF_CMPL)) m_per[31:0]  = bus_wdata;
            if (n_wr && bus_addr == 5'(OFF_CMPH)) m_per[63:32] = bus_wdata;
            if (n_hit) m_stat = 1;
            else if (n_wr && bus_addr == 5'(OFF_STAT) && bus_wdata[0]) m_stat = 0;
            if (n_wr && bus_addr == 5'(OFF_CFG)) begin
                m_nw = bus_wdata[3]; m_ps = bus_wdata[2]; m_pm = bus_wdata[1]; m_ie = bus_wdata[0];
            end else if (n_wr && (bus_addr == 5'(OFF_CMPL) || bus_addr == 5'(OFF_CMPH))) m_ps = 0;
            if (n_wr && bus_addr == 5'(OFF_RUN)) m_run = bus_wdata[0];
            m_cnt = n_cnt;
            m_cmp = n_cmp;
        end
    end

    function automatic logic [31:0] m_read(input int a);
        case (a)
            OFF_RUN:  return {31'd0, m_run};
            OFF_STAT: return {31'd0, m_stat};
            OFF_CNTL: return m_cnt[31:0];
            OFF_CNTH: return m_nw ? 32'd0 : m_cnt[63:32];
            OFF_CFG:  return {28'd0, m_nw, m_ps, m_pm, m_ie};
            OFF_CMPL: return m_cmp[31:0];
            OFF_CMPH: return m_cmp[63:32];
            default:  return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle irq comparison against the model (R6)
    always @(negedge clk) begin
        if (!rst && !done) chk(irq == (m_stat && m_ie), "R6 irq vs model", {31'd0, irq}, {31'd0, m_stat && m_ie});
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input int a, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = 5'(a);
        #1 v = bus_rdata;
        chk(v == m_read(a), tag, v, m_read(a));
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h1, h2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: reset state
        for (int a = 0; a <= 24; a += 4) begin
            rd(a, "R1 reset read", v);
            chk(v == 0, "R1 reset value", v, 0);
        end
        chk(irq == 0, "R1 irq low", {31'd0, irq}, 0);

        // R3: split read across a low-word carry
        wr(OFF_CNTL, 32'hFFFF_FFFD);
        wr(OFF_CNTH, 32'd7);
        wr(OFF_RUN, 1);
        rd(OFF_CNTH, "R3 first high", h1);
        idle(2);
        rd(OFF_CNTL, "R3 low after carry", v);
        chk(v == 0, "R3 low wrapped", v, 0);
        rd(OFF_CNTH, "R3 second high", h2);
        chk(h1 == 7, "R3 high before carry", h1, 7);
        chk(h2 == 8, "R3 high after carry", h2, 8);
        idle(5);
        rd(OFF_CNTL, "R4 counting", v);

        // R2: counter load only while halted
        wr(OFF_RUN, 0);
        wr(OFF_CNTL, 32'd100);
        wr(OFF_CNTH, 32'd0);
        rd(OFF_CNTL, "R2 halted load", v);
        chk(v == 100, "R2 halted load value", v, 100);
        wr(OFF_RUN, 1);
        wr(OFF_CNTL, 32'd5);
        rd(OFF_CNTL, "R2 running write ignored", v);
        chk(v != 5, "R2 running write ignored", v, 32'd5);

        // R5/R6: one-shot match and clear
        wr(OFF_RUN, 0);
        wr(OFF_CNTL, 0);
        wr(OFF_CFG, 32'h1);
        wr(OFF_CMPL, 32'd20);
        wr(OFF_CMPH, 0);
        wr(OFF_RUN, 1);
        idle(30);
        chk(irq == 1, "R5 one-shot irq", {31'd0, irq}, 1);
        rd(OFF_CMPL, "R5 comparator kept", v);
        chk(v == 20, "R5 comparator kept", v, 20);
        wr(OFF_STAT, 1);
        rd(OFF_STAT, "R6 status cleared", v);
        chk(v == 0, "R6 status cleared", v, 0);

        // R7/R8: periodic mode with preset
        wr(OFF_RUN, 0);
        wr(OFF_CNTL, 0);
        wr(OFF_CFG, 32'h7);
        wr(OFF_CMPL, 32'd10);
        rd(OFF_CFG, "R7 preset cleared", v);
        chk(v == 32'h3, "R7 preset cleared", v, 32'h3);
        wr(OFF_CFG, 32'h7);
        wr(OFF_CMPH, 0);
        wr(OFF_RUN, 1);
        idle(14);
        rd(OFF_CMPL, "R8 periodic reload", v);
        chk(v == 20, "R8 reload by period", v, 20);
        wr(OFF_CMPL, 32'd5);
        rd(OFF_CMPL, "R7 period-only write", v);
        chk(v == 20, "R7 comparator untouched", v, 20);
        idle(6);
        rd(OFF_CMPL, "R8 reload by new period", v);
        idle(20);
        rd(OFF_CMPL, "R8 later reloads", v);
        wr(OFF_STAT, 1);

        // R11: match and clear in the same cycle
        wr(OFF_RUN, 0);
        wr(OFF_CFG, 32'h1);
        wr(OFF_CNTL, 32'd50);
        wr(OFF_CNTH, 0);
        wr(OFF_CMPL, 32'd50);
        wr(OFF_CMPH, 0);
        wr(OFF_STAT, 1);
        wr(OFF_RUN, 1);
        wr(OFF_STAT, 1);
        rd(OFF_STAT, "R11 match beats clear", v);
        chk(v == 1, "R11 match beats clear", v, 1);

        // R12: direct load and reload in the same cycle; R6 gating
        wr(OFF_RUN, 0);
        wr(OFF_STAT, 1);
        wr(OFF_CFG, 32'h6);
        wr(OFF_CMPL, 32'd60);
        wr(OFF_CNTL, 32'd60);
        wr(OFF_CFG, 32'h6);
        wr(OFF_RUN, 1);
        wr(OFF_CMPL, 32'd99);
        rd(OFF_CMPL, "R12 write beats reload", v);
        chk(v == 99, "R12 write beats reload", v, 99);
        rd(OFF_STAT, "R6 status set without enable", v);
        chk(v == 1 && irq == 0, "R6 irq gated off", {31'd0, irq}, 0);

        // R9/R10: narrow mode
        wr(OFF_RUN, 0);
        wr(OFF_CFG, 32'h9);
        wr(OFF_CNTL, 32'hFFFF_FFF0);
        wr(OFF_CNTH, 32'd3);
        rd(OFF_CNTH, "R10 high ignored", v);
        chk(v == 0, "R10 high reads zero", v, 0);
        wr(OFF_CMPL, 32'hFFFF_FFF8);
        wr(OFF_CMPH, 32'h1234);
        wr(OFF_STAT, 1);
        wr(OFF_RUN, 1);
        idle(20);
        rd(OFF_CNTH, "R10 high after wrap", v);
        chk(v == 0, "R10 no carry upward", v, 0);
        rd(OFF_CNTL, "R10 low wrapped", v);
        chk(v < 32'h20, "R10 low wrapped", v, 32'h20);
        rd(OFF_STAT, "R9 low-word match", v);
        chk(v == 1, "R9 upper comparator ignored", v, 1);

        // R8: narrow periodic reload wraps within 32 bits
        wr(OFF_RUN, 0);
        wr(OFF_CFG, 32'hE);
        wr(OFF_CMPL, 32'hFFFF_FFFA);
        wr(OFF_CNTL, 32'hFFFF_FFF0);
        wr(OFF_RUN, 1);
        idle(20);
        rd(OFF_CMPL, "R8 narrow reload", v);
        chk(v == 32'hFFFF_FFF4, "R8 narrow reload wraps", v, 32'hFFFF_FFF4);
        rd(OFF_CMPH, "R8 narrow upper kept", v);
        chk(v == 32'h1234, "R8 narrow upper kept", v, 32'h1234);

        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule